// File: doc/BRIEF.md
# Packed Pairwise Multiply-Accumulate Unit

This block performs one step of a fixed-point dot product on 128-bit vectors. Each operand holds eight signed 16-bit lanes. The unit multiplies each lane of the first operand by the matching lane of the second. It then adds the two products of every adjacent lane pair, which gives four signed 32-bit sums packed into a 128-bit result. All four pair sums are formed in parallel from one operand pair. The result is registered, so it appears one clock after the operands are presented.

Typical uses are a FIR tap stage or the inner step of a longer dot product. A downstream adder combines the four sums or accumulates them across cycles. The output is never saturated. A pair sum can only leave the signed 32-bit range in one case: when all four of its inputs hold the most negative 16-bit value. That case wraps to 0x80000000.

Top module: `pair_mac_unit`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `out_valid` and every bit of `result` are 0 after that edge.
- R2: `out_valid` is 1 in the cycle after a rising edge that sampled `in_valid` high, and 0 in the cycle after an edge that sampled it low.
- R3: Input lane k (k = 0..7) occupies bits [16k+15:16k] of `op_a` and of `op_b`, in two's complement. Output lane j (j = 0..3) occupies bits [32j+31:32j] of `result` and equals op_a[2j]*op_b[2j] + op_a[2j+1]*op_b[2j+1], truncated to 32 bits.
- R4: When the four inputs of one pair are all 0x8000, that output lane is 0x80000000, with no saturation. The other lanes still follow R3.
- R5: An edge that samples `in_valid` low leaves `result` unchanged, whatever `op_a` and `op_b` hold.
- R6: For every input combination other than the one in R4, the pair sum is exact in signed 32 bits. This includes mixed-sign products and the extreme values 0x7FFF and 0x8000.
- R7: The four output lanes are computed independently within one operation. Each lane depends only on its own four input lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and should be processed |
| op_a | input | 128 | First operand, eight signed 16-bit lanes |
| op_b | input | 128 | Second operand, eight signed 16-bit lanes |
| out_valid | output | 1 | `result` holds a newly computed value |
| result | output | 128 | Four signed 32-bit pair sums |

## Verification
The assertions assume that `rst` is held high for at least one edge at start-up. They also assume that `op_a` and `op_b` carry known values whenever `in_valid` is high, because the overflow and wrap properties inspect the lane values on those cycles. The bench drives every operand bit from defined random or directed data, and it changes the operands only on falling edges. Random lanes are sometimes drawn from a small set of extreme codes, so the wrap case and the mixed-sign cases near the range limits occur often, alongside fully random words.

// File: rtl/pair_mac_unit.sv
module pair_mac_unit #(
  parameter int LW    = 16,
  parameter int PAIRS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2*PAIRS*LW-1:0]   op_a,
  input  logic [2*PAIRS*LW-1:0]   op_b,
  output logic                    out_valid,
  output logic [2*PAIRS*LW-1:0]   result
);
  localparam int OW  = 2 * LW;
  localparam int VW  = PAIRS * OW;
  localparam logic [LW-1:0] LMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic [OW-1:0] OMIN = {1'b1, {(OW-1){1'b0}}};

  logic [VW-1:0] sum_w;

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic signed [LW-1:0] a0, a1, b0, b1;
    logic signed [OW-1:0] p0, p1;
    logic [OW:0] s;

    assign a0 = op_a[(2*j)*LW +: LW];
    assign a1 = op_a[(2*j+1)*LW +: LW];
    assign b0 = op_b[(2*j)*LW +: LW];
    assign b1 = op_b[(2*j+1)*LW +: LW];
    assign p0 = a0 * b0;
    assign p1 = a1 * b1;
    assign s  = {p0[OW-1], p0} + {p1[OW-1], p1};
    assign sum_w[j*OW +: OW] = s[OW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (s[OW] != s[OW-1])) |-> (a0 == LMIN && a1 == LMIN && b0 == LMIN && b1 == LMIN)); // R6
    AST_WRAP_PAIR: assert property (@(posedge clk) disable iff (rst)
      (in_valid && a0 == LMIN && a1 == LMIN && b0 == LMIN && b1 == LMIN) |=> (result[j*OW +: OW] == OMIN)); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sum_w;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0)); // R1
endmodule

// File: tb/tb_pair_mac_unit.sv
module tb_pair_mac_unit;
  logic clk = 1'b0;
  logic rst, in_valid;
  logic [127:0] op_a, op_b;
  logic out_valid;
  logic [127:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pair_mac_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a),
                     .op_b(op_b), .out_valid(out_valid), .result(result));

  function automatic logic [127:0] ref_mac(logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    for (int j = 0; j < 4; j++) begin
      longint s;
      s = longint'($signed(a[32*j +: 16])) * longint'($signed(b[32*j +: 16]))
        + longint'($signed(a[32*j+16 +: 16])) * longint'($signed(b[32*j+16 +: 16]));
      r[32*j +: 32] = s[31:0];
    end
    return r;
  endfunction

  function automatic logic [15:0] pick_lane();
    logic [15:0] ext [5] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'h0000};
    if ($urandom_range(3) == 0) return ext[$urandom_range(4)];
    return 16'($urandom);
  endfunction

  function automatic logic [127:0] rand_vec();
    logic [127:0] v;
    for (int k = 0; k < 8; k++) v[16*k +: 16] = pick_lane();
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [127:0] a, logic [127:0] b, string req);
    logic [127:0] e;
    e = ref_mac(a, b);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2 out_valid after in_valid", {127'd0, out_valid}, 128'd1);
    chk(result == e, req, result, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held, a, b;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b1; op_a = '1; op_b = '1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && result == '0, "R1 reset state", result, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle after reset", {127'd0, out_valid}, '0);

    // R3 simple positive lanes
    apply({16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1},
          {16'd1,16'd2,16'd3,16'd4,16'd5,16'd6,16'd7,16'd8}, "R3 small positives");
    // R4 wrap on every pair
    apply({8{16'h8000}}, {8{16'h8000}}, "R4 all pairs wrap");
    chk(result == {4{32'h80000000}}, "R4 wrap value", result, {4{32'h80000000}});
    // R4 wrap on one pair only, R7 neighbours independent
    apply({16'h0003,16'hFFFE,16'h7FFF,16'h8000,16'h8000,16'h8000,16'h0005,16'h0004},
          {16'h0002,16'h0009,16'h7FFF,16'h7FFF,16'h8000,16'h8000,16'hFFFF,16'h0006},
          "R4 R7 single wrap pair");
    chk(result[63:32] == 32'h80000000, "R4 lane1 wrap", result, {96'd0, 32'h80000000});
    // R6 mixed signs and extremes
    apply({16'h8000,16'h8000,16'h7FFF,16'h7FFF,16'h8000,16'h7FFF,16'hFFFF,16'h8000},
          {16'h7FFF,16'h7FFF,16'h7FFF,16'h7FFF,16'h8000,16'h7FFF,16'h8000,16'h8000},
          "R6 extreme mixed");
    apply({16'hFFFF,16'h0001,16'h8000,16'h0000,16'h7FFF,16'h8001,16'hFFFE,16'h0002},
          {16'h0001,16'hFFFF,16'hFFFF,16'h1234,16'h8001,16'h7FFF,16'hFFFE,16'hFFFE},
          "R6 mixed sign pairs");
    // R7 one nonzero pair
    apply({96'd0, 16'h0100, 16'h0010}, {96'd0, 16'h0100, 16'h0010}, "R7 isolated pair");
    chk(result[127:32] == '0, "R7 other lanes zero", result, {96'd0, 32'h00010100});

    // R5 hold with changing operands
    held = result;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_a = rand_vec(); op_b = rand_vec();
      chk(result == held, "R5 hold while idle", result, held);
      chk(out_valid == 1'b0, "R2 idle low", {127'd0, out_valid}, '0);
    end

    // R3 R6 random, some back-to-back
    for (int i = 0; i < 300; i++) begin
      a = rand_vec(); b = rand_vec();
      if (i % 3 == 0) begin
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        chk(out_valid && result == ref_mac(a, b), "R3 back-to-back random", result, ref_mac(a, b));
        a = rand_vec(); b = rand_vec();
        op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && result == ref_mac(a, b), "R3 back-to-back random 2", result, ref_mac(a, b));
      end else begin
        apply(a, b, "R3 R6 random");
      end
    end

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && result == '0, "R1 reset mid-run", result, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule